// File: doc/BRIEF.md
# Command Block Register-List Sequencer

The sequencer takes the byte address of a command parameter block in memory and executes it. It reads the block header from a 32-bit synchronous read port and checks the valid flag. It keeps the length field, the interrupt request flag and the data phase flag, and captures the next-block pointer and the scatter/gather chain pointer. It then walks the register list that starts at byte 16. Each two-byte entry becomes one write on the disk task-file register port, unless the entry is marked skip. The walk stops at the entry marked as final.

When the block asks for a data phase, the sequencer pulses a kick output and presents the chain pointer to a separate walker. It then waits for that walker to report the end of the transfer. Last, it writes a completion code into the response byte at offset 0 of the block and pulses `done_o`. It also pulses `irq_o` when the block requested an interrupt.

A block with its valid flag clear is not executed. A register list that has no final entry within the space given by the length field is cut off. Both cases report failure through the response byte.

Top module: `cmdblk_seq`

## Requirements
- R1: Header byte 2 (read word 0, bits 23:16) gives the flags: bit 0 valid, bit 2 data phase, bit 3 interrupt request. Bytes 4..7 and 8..11 are little-endian 32-bit pointers, driven on `next_ptr_o` and `prd_ptr_o` once they have been read.
- R2: The list starts at byte 16 and is read as little-endian words. Each entry is a value byte followed by a control byte, and a word holds two entries with the lower one first. Entries are replayed in list order as single-cycle writes. `reg_data_o` carries the value byte and `reg_addr_o` carries control bits 4:0.
- R3: An entry whose control bit 5 is set produces no register write.
- R4: An entry whose control bit 7 is set ends the list. No entry after it is written, including the second entry of the same word.
- R5: Header byte 3 holds L, and the list may occupy only bytes 16 to 16+8L-1. If no final entry is found in that range, or L is 0, the block fails. The walk then reads no word past that range.
- R6: A header with the valid bit clear causes no register write and no further memory read, and the block fails.
- R7: At completion, one write-back of the response byte goes to the block base address. It carries 0x01 on success and 0x80 on failure, and `done_o` pulses in the same cycle.
- R8: If the data phase flag is set, `prd_start_o` pulses once after the final entry. Completion then waits for `xfer_done_i`, and `xfer_err_i` sampled with it turns the result into failure.
- R9: `irq_o` pulses together with `done_o` only when the interrupt request flag was set.
- R10: `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start executing the block at `blk_addr_i` |
| blk_addr_i | input | AW | Byte address of the block, 8-byte aligned |
| busy_o | output | 1 | Sequencer is executing a block |
| rd_req_o | output | 1 | Memory word read request |
| rd_addr_o | output | AW | Byte address of the word read |
| rd_data_i | input | 32 | Read data, valid in the cycle after the request |
| wb_valid_o | output | 1 | Response byte write strobe |
| wb_addr_o | output | AW | Response byte address |
| wb_data_o | output | 8 | Response code |
| reg_wr_valid_o | output | 1 | Task-file register write strobe |
| reg_addr_o | output | 5 | Target register address |
| reg_data_o | output | 8 | Register value |
| next_ptr_o | output | 32 | Next-block pointer from the header |
| prd_ptr_o | output | 32 | Scatter/gather chain pointer from the header |
| prd_start_o | output | 1 | Kick pulse to the chain walker |
| xfer_done_i | input | 1 | Walker reports the end of the transfer |
| xfer_err_i | input | 1 | Walker reports a failed transfer, valid with `xfer_done_i` |
| done_o | output | 1 | Completion pulse |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The list walk is tried with several blocks. A short-address command without a data phase checks order and skip handling against a straight copy. A long-address command with a data phase shows that the high-order writes come first and that completion waits for the walker. A final entry placed in the lower half of a word shows that the walk stops inside a word. Invalid headers, a zero length, a list with its final entry placed past the length limit, a failed transfer and a second start pulse while busy tell apart the abort paths, the read bound and the response codes.

// File: rtl/cmdblk_pkg.sv
package cmdblk_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_CAP, S_EMIT0, S_EMIT1, S_KICK, S_XFER, S_WB
  } state_e;

  typedef struct packed {
    logic [7:0] value;
    logic [4:0] addr;
    logic       skip;
    logic       last;
  } entry_t;

  localparam int unsigned FLG_VLD = 16;  // header byte 2 bits inside word 0
  localparam int unsigned FLG_DAT = 18;
  localparam int unsigned FLG_IEN = 19;
  localparam int unsigned LIST_W0 = 4;   // first list word, byte 16

  localparam logic [7:0] RESP_OK   = 8'h01;
  localparam logic [7:0] RESP_FAIL = 8'h80;
endpackage

// File: rtl/cmdblk_entry_dec.sv
module cmdblk_entry_dec
  import cmdblk_pkg::*;
(
  input  logic [15:0] raw_i,
  output entry_t      ent_o
);
  always_comb begin
    ent_o.value = raw_i[7:0];
    ent_o.addr  = raw_i[12:8];
    ent_o.skip  = raw_i[13];
    ent_o.last  = raw_i[15];
  end
endmodule

// File: rtl/cmdblk_fsm.sv
module cmdblk_fsm
  import cmdblk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] blk_addr_i,
  input  logic [31:0]   rd_data_i,
  input  logic          last0_i,
  input  logic          last1_i,
  input  logic          xfer_done_i,
  input  logic          xfer_err_i,
  output state_e        state_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] base_o,
  output logic [31:0]   list_word_o,
  output logic [31:0]   next_ptr_o,
  output logic [31:0]   prd_ptr_o,
  output logic          hdr_valid_o,
  output logic          ien_o,
  output logic          err_o
);
  localparam int unsigned IW = LW + 2;

  state_e        state_q;
  logic [AW-1:0] base_q;
  logic [IW-1:0] widx_q;
  logic [LW-1:0] len_q;
  logic          vld_q, data_q, ien_q, err_q;
  logic [31:0]   lw_q, next_q, prd_q;
  logic [IW-1:0] lim;

  // last list word index: 3 + 2L
  assign lim = IW'(LIST_W0 - 1) + IW'({len_q, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      widx_q  <= '0;
      len_q   <= '0;
      vld_q   <= 1'b0;
      data_q  <= 1'b0;
      ien_q   <= 1'b0;
      err_q   <= 1'b0;
      lw_q    <= '0;
      next_q  <= '0;
      prd_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          base_q  <= blk_addr_i;
          widx_q  <= '0;
          err_q   <= 1'b0;
          vld_q   <= 1'b0;
          state_q <= S_RD;
        end
        S_RD: state_q <= S_CAP;
        S_CAP: begin
          if (widx_q == IW'(0)) begin
            len_q  <= rd_data_i[31:24];
            vld_q  <= rd_data_i[FLG_VLD];
            data_q <= rd_data_i[FLG_DAT];
            ien_q  <= rd_data_i[FLG_IEN];
            if (!rd_data_i[FLG_VLD]) begin
              err_q   <= 1'b1;
              state_q <= S_WB;
            end else begin
              widx_q  <= IW'(1);
              state_q <= S_RD;
            end
          end else if (widx_q == IW'(1)) begin
            next_q  <= rd_data_i;
            widx_q  <= IW'(2);
            state_q <= S_RD;
          end else if (widx_q == IW'(2)) begin
            prd_q  <= rd_data_i;
            widx_q <= IW'(LIST_W0);
            if (len_q == '0) begin
              err_q   <= 1'b1;
              state_q <= S_WB;
            end else begin
              state_q <= S_RD;
            end
          end else begin
            lw_q    <= rd_data_i;
            state_q <= S_EMIT0;
          end
        end
        S_EMIT0: begin
          if (last0_i) state_q <= data_q ? S_KICK : S_WB;
          else         state_q <= S_EMIT1;
        end
        S_EMIT1: begin
          if (last1_i) begin
            state_q <= data_q ? S_KICK : S_WB;
          end else if (widx_q == lim) begin
            err_q   <= 1'b1;
            state_q <= S_WB;
          end else begin
            widx_q  <= widx_q + IW'(1);
            state_q <= S_RD;
          end
        end
        S_KICK: state_q <= S_XFER;
        S_XFER: if (xfer_done_i) begin
          err_q   <= xfer_err_i;
          state_q <= S_WB;
        end
        S_WB:    state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign rd_req_o    = (state_q == S_RD);
  assign rd_addr_o   = base_q + AW'({widx_q, 2'b00});
  assign base_o      = base_q;
  assign list_word_o = lw_q;
  assign next_ptr_o  = next_q;
  assign prd_ptr_o   = prd_q;
  assign hdr_valid_o = vld_q;
  assign ien_o       = ien_q;
  assign err_o       = err_q;

  AST_WORD_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CAP && widx_q >= IW'(LIST_W0)) |-> (widx_q <= lim)); // R5
  AST_KICK_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_KICK) |-> data_q); // R8
  AST_PRD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_XFER) |=> $stable(prd_q)); // R8
endmodule

// File: rtl/cmdblk_seq.sv
module cmdblk_seq
  import cmdblk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] blk_addr_i,
  output logic          busy_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [31:0]   rd_data_i,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_addr_o,
  output logic [7:0]    wb_data_o,
  output logic          reg_wr_valid_o,
  output logic [4:0]    reg_addr_o,
  output logic [7:0]    reg_data_o,
  output logic [31:0]   next_ptr_o,
  output logic [31:0]   prd_ptr_o,
  output logic          prd_start_o,
  input  logic          xfer_done_i,
  input  logic          xfer_err_i,
  output logic          done_o,
  output logic          irq_o
);
  state_e        state;
  logic [31:0]   lw;
  logic [AW-1:0] base;
  logic          hdr_valid, ien, err;
  entry_t        ent [2];
  entry_t        cur;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    cmdblk_entry_dec u_dec (
      .raw_i (lw[16*g +: 16]),
      .ent_o (ent[g])
    );
  end

  cmdblk_fsm #(.AW(AW), .LW(LW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .blk_addr_i  (blk_addr_i),
    .rd_data_i   (rd_data_i),
    .last0_i     (ent[0].last),
    .last1_i     (ent[1].last),
    .xfer_done_i (xfer_done_i),
    .xfer_err_i  (xfer_err_i),
    .state_o     (state),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .base_o      (base),
    .list_word_o (lw),
    .next_ptr_o  (next_ptr_o),
    .prd_ptr_o   (prd_ptr_o),
    .hdr_valid_o (hdr_valid),
    .ien_o       (ien),
    .err_o       (err)
  );

  assign cur            = (state == S_EMIT1) ? ent[1] : ent[0];
  assign reg_wr_valid_o = ((state == S_EMIT0) || (state == S_EMIT1)) && !cur.skip;
  assign reg_addr_o     = cur.addr;
  assign reg_data_o     = cur.value;
  assign busy_o         = (state != S_IDLE);
  assign prd_start_o    = (state == S_KICK);
  assign wb_valid_o     = (state == S_WB);
  assign wb_addr_o      = base;
  assign wb_data_o      = err ? RESP_FAIL : RESP_OK;
  assign done_o         = (state == S_WB);
  assign irq_o          = (state == S_WB) && ien;

  AST_ONE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_wr_valid_o, rd_req_o, wb_valid_o})); // R2
  AST_WR_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_valid_o |-> hdr_valid); // R6
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !reg_wr_valid_o)); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R10
endmodule

// File: tb/cmdblk_seq_tb.sv
module cmdblk_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] blk_addr_i = '0;
  logic [31:0] rd_data_i = '0;
  logic        xfer_done_i = 1'b0;
  logic        xfer_err_i = 1'b0;
  logic        busy_o, rd_req_o, wb_valid_o, reg_wr_valid_o, prd_start_o, done_o, irq_o;
  logic [31:0] rd_addr_o, wb_addr_o, next_ptr_o, prd_ptr_o;
  logic [7:0]  wb_data_o, reg_data_o;
  logic [4:0]  reg_addr_o;

  always #4 clk = ~clk;

  cmdblk_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .blk_addr_i(blk_addr_i),
    .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
    .reg_wr_valid_o(reg_wr_valid_o), .reg_addr_o(reg_addr_o), .reg_data_o(reg_data_o),
    .next_ptr_o(next_ptr_o), .prd_ptr_o(prd_ptr_o), .prd_start_o(prd_start_o),
    .xfer_done_i(xfer_done_i), .xfer_err_i(xfer_err_i), .done_o(done_o), .irq_o(irq_o)
  );

  logic [7:0]  mem [256];
  logic [4:0]  wa [32];
  logic [7:0]  wd [32];
  int          wr_n, rd_n, done_n, irq_n, kick_n, wb_n;
  logic [31:0] wb_a;
  logic [7:0]  wb_d;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rd_req_o) begin
      rd_n <= rd_n + 1;
      rd_data_i <= {mem[8'(rd_addr_o + 3)], mem[8'(rd_addr_o + 2)],
                    mem[8'(rd_addr_o + 1)], mem[8'(rd_addr_o)]};
    end
    if (reg_wr_valid_o) begin
      if (wr_n < 32) begin wa[wr_n] <= reg_addr_o; wd[wr_n] <= reg_data_o; end
      wr_n <= wr_n + 1;
    end
    if (wb_valid_o) begin wb_n <= wb_n + 1; wb_a <= wb_addr_o; wb_d <= wb_data_o; end
    if (done_o) done_n <= done_n + 1;
    if (irq_o) irq_n <= irq_n + 1;
    if (prd_start_o) kick_n <= kick_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_logs();
    @(negedge clk);
    wr_n = 0; rd_n = 0; done_n = 0; irq_n = 0; kick_n = 0; wb_n = 0; wb_a = '1; wb_d = '0;
  endtask

  task automatic put_hdr(input int b, input logic [7:0] flg, input logic [7:0] len,
                         input logic [31:0] nxt, input logic [31:0] prd);
    mem[b] = 8'h00; mem[b+1] = 8'h00; mem[b+2] = flg; mem[b+3] = len;
    for (int i = 0; i < 4; i++) begin
      mem[b+4+i] = nxt[8*i +: 8];
      mem[b+8+i] = prd[8*i +: 8];
      mem[b+12+i] = 8'h00;
    end
  endtask

  task automatic put_ent(input int b, input int idx, input logic [7:0] v, input logic [7:0] c);
    mem[b+16+2*idx] = v; mem[b+17+2*idx] = c;
  endtask

  task automatic run(input int b, input bit data, input bit xerr);
    @(negedge clk);
    blk_addr_i = 32'(b); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (data) begin
      while (kick_n == 0) @(negedge clk);
      repeat (5) @(negedge clk);
      xfer_done_i = 1'b1; xfer_err_i = xerr;
      @(negedge clk);
      xfer_done_i = 1'b0; xfer_err_i = 1'b0;
    end
    while (done_n == 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy_o && !reg_wr_valid_o && !done_o && !rd_req_o && !wb_valid_o && !irq_o,
        "R7 reset idle", {busy_o, reg_wr_valid_o, done_o, rd_req_o}, 0);
  endtask

  // short-address command, no data phase, skip entry inside
  task automatic t_short();
    logic [4:0] ea [7] = '{5'h16, 5'h12, 5'h13, 5'h14, 5'h15, 5'h0E, 5'h17};
    logic [7:0] ed [7] = '{8'hE0, 8'h08, 8'h11, 8'h22, 8'h33, 8'h00, 8'hC8};
    put_hdr(0, 8'h09, 8'd2, 32'h11223344, 32'h55667788);
    put_ent(0, 0, 8'hE0, 8'h16); put_ent(0, 1, 8'h08, 8'h12);
    put_ent(0, 2, 8'h11, 8'h13); put_ent(0, 3, 8'h22, 8'h14);
    put_ent(0, 4, 8'h33, 8'h15); put_ent(0, 5, 8'h00, 8'h0E);
    put_ent(0, 6, 8'h99, 8'h32); put_ent(0, 7, 8'hC8, 8'h97);
    clr_logs();
    run(0, 0, 0);
    chk(wr_n == 7, "R3 skip count", wr_n, 7);
    for (int i = 0; i < 7; i++)
      chk(wa[i] == ea[i] && wd[i] == ed[i], "R2 order", {wa[i], wd[i]}, {ea[i], ed[i]});
    chk(next_ptr_o == 32'h11223344, "R1 next ptr", next_ptr_o, 32'h11223344);
    chk(prd_ptr_o == 32'h55667788, "R1 prd ptr", prd_ptr_o, 32'h55667788);
    chk(wb_n == 1 && wb_a == 0 && wb_d == 8'h01, "R7 ok resp", wb_d, 1);
    chk(done_n == 1 && kick_n == 0, "R8 no kick", kick_n, 0);
    chk(irq_n == 1, "R9 irq set", irq_n, 1);
  endtask

  // long-address command with data phase, optional walker error
  task automatic t_long(input bit xerr);
    logic [4:0] ea [11] = '{5'h16, 5'h12, 5'h13, 5'h14, 5'h15, 5'h12, 5'h13, 5'h14, 5'h15, 5'h0E, 5'h17};
    logic [7:0] ed [11] = '{8'h40, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h00, 8'h25};
    put_hdr(64, 8'h0D, 8'd3, 32'hCAFE0000, 32'hA0B0C0D0);
    for (int i = 0; i < 10; i++) put_ent(64, i, ed[i], {3'b000, ea[i]});
    put_ent(64, 10, 8'h00, 8'h20);
    put_ent(64, 11, 8'h25, 8'h97);
    clr_logs();
    run(64, 1, xerr);
    chk(wr_n == 11, "R2 long count", wr_n, 11);
    for (int i = 0; i < 11; i++)
      chk(wa[i] == ea[i] && wd[i] == ed[i], "R2 high first", {wa[i], wd[i]}, {ea[i], ed[i]});
    chk(kick_n == 1, "R8 kick once", kick_n, 1);
    chk(prd_ptr_o == 32'hA0B0C0D0, "R8 prd ptr", prd_ptr_o, 32'hA0B0C0D0);
    chk(wb_a == 64 && wb_d == (xerr ? 8'h80 : 8'h01), "R8 resp", wb_d, xerr ? 8'h80 : 8'h01);
  endtask

  task automatic t_invalid();
    put_hdr(128, 8'h08, 8'd2, 32'h0, 32'h0);
    put_ent(128, 0, 8'h12, 8'h12); put_ent(128, 1, 8'h34, 8'h97);
    clr_logs();
    run(128, 0, 0);
    chk(wr_n == 0, "R6 no writes", wr_n, 0);
    chk(rd_n == 1, "R6 one read", rd_n, 1);
    chk(wb_a == 128 && wb_d == 8'h80, "R6 fail resp", wb_d, 8'h80);
  endtask

  task automatic t_noend();
    put_hdr(160, 8'h01, 8'd1, 32'h0, 32'h0);
    put_ent(160, 0, 8'hA1, 8'h12); put_ent(160, 1, 8'hA2, 8'h13);
    put_ent(160, 2, 8'hA3, 8'h14); put_ent(160, 3, 8'hA4, 8'h15);
    put_ent(160, 4, 8'hA5, 8'h97); put_ent(160, 5, 8'hA6, 8'h97);
    clr_logs();
    run(160, 0, 0);
    chk(wr_n == 4, "R5 limit writes", wr_n, 4);
    chk(rd_n == 5, "R5 limit reads", rd_n, 5);
    chk(wb_d == 8'h80, "R5 limit fail", wb_d, 8'h80);
    chk(irq_n == 0, "R9 no irq", irq_n, 0);
  endtask

  task automatic t_zero_len();
    put_hdr(192, 8'h01, 8'd0, 32'h0, 32'h0);
    put_ent(192, 0, 8'h55, 8'h97);
    clr_logs();
    run(192, 0, 0);
    chk(wr_n == 0 && rd_n == 3, "R5 zero length", {wr_n[7:0], rd_n[7:0]}, 16'h0003);
    chk(wb_d == 8'h80, "R5 zero fail", wb_d, 8'h80);
  endtask

  // final entry in the lower half of a word
  task automatic t_end_low();
    put_hdr(0, 8'h01, 8'd1, 32'h0, 32'h0);
    put_ent(0, 0, 8'h01, 8'h12); put_ent(0, 1, 8'h02, 8'h13);
    put_ent(0, 2, 8'hEC, 8'h97); put_ent(0, 3, 8'h77, 8'h14);
    clr_logs();
    run(0, 0, 0);
    chk(wr_n == 3, "R4 stop count", wr_n, 3);
    chk(wa[2] == 5'h17 && wd[2] == 8'hEC, "R4 last entry", {wa[2], wd[2]}, {5'h17, 8'hEC});
    chk(wb_d == 8'h01 && irq_n == 0, "R9 irq clear", irq_n, 0);
  endtask

  task automatic t_busy_start();
    put_hdr(0, 8'h09, 8'd2, 32'h11223344, 32'h55667788);
    put_ent(0, 0, 8'hE0, 8'h16); put_ent(0, 1, 8'h08, 8'h12);
    put_ent(0, 2, 8'h11, 8'h13); put_ent(0, 3, 8'h22, 8'h14);
    put_ent(0, 4, 8'h33, 8'h15); put_ent(0, 5, 8'h00, 8'h0E);
    put_ent(0, 6, 8'h99, 8'h32); put_ent(0, 7, 8'hC8, 8'h97);
    clr_logs();
    @(negedge clk);
    blk_addr_i = 32'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    blk_addr_i = 32'd128; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (done_n == 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(done_n == 1 && wb_n == 1, "R10 one completion", done_n, 1);
    chk(wb_a == 0 && wb_d == 8'h01, "R10 first block", wb_a, 0);
    chk(wr_n == 7 && !busy_o, "R10 writes", wr_n, 7);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wr_n = 0; rd_n = 0; done_n = 0; irq_n = 0; kick_n = 0; wb_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_short();
    t_long(1'b0);
    t_invalid();
    t_noend();
    t_zero_len();
    t_end_low();
    t_long(1'b1);
    t_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule